// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when a dynamic RAM array receives its row refresh cycles and shares the array between those cycles and ordinary processor accesses. A free-running timer marks each refresh period and divides it into equal slots. A row counter supplies the address of the next row to refresh. An arbiter grants processor accesses and inserts refresh cycles. The cell array, column addressing and the DRAM pin sequencing are outside the block. It reports only that a refresh cycle is happening and which row it covers.

Three policies can be selected at run time. The burst policy refreshes every row back to back at the start of each period and locks the processor out while it does so. The interleaved policy appends one refresh clock to every memory cycle, so the processor never meets a lock-out but each of its cycles is one clock longer. The spread policy places one row refresh in each slot of the period, so the lock-out lasts only a single clock at a time. The policy input is read only on the first clock of a period.

The period length in clocks comes from the clock rate and the required retention time. The slot spacing is that length divided by the number of rows.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, `cpu_gnt_o`, `busy_o`, `ref_stb_o` and `period_done_o` are low and `ref_row_o` is 0.
- R2: Each clock with `ref_stb_o` high refreshes exactly the row on `ref_row_o`. After every refresh clock the row advances by one, and after row ROWS-1 it returns to 0. Without a refresh the row does not change.
- R3: `period_done_o` is high in exactly those clocks that refresh row ROWS-1. After such a clock the row is 0.
- R4: Burst policy (mode code 0). When no access is in progress at the start of a period, refresh clocks fill period offsets 2 to ROWS+1 back to back. `busy_o` is high exactly on those clocks.
- R5: Interleaved policy (mode code 1). `busy_o` never rises. Every memory cycle is ACC_CYCLES clocks, with or without a processor access, and is followed by exactly one refresh clock. A refresh therefore follows in the clock after `cpu_gnt_o` falls, and refresh clocks are ACC_CYCLES+1 clocks apart.
- R6: Spread policy (mode codes 2 and 3). The slot length is PERIOD_CLKS/ROWS, where PERIOD_CLKS = CLK_KHZ*PERIOD_US/1000. With the processor idle, a refresh falls 2 clocks after each slot boundary, and `busy_o` is high for that one clock only.
- R7: Under the burst and spread policies, a refresh falls due at a slot or period boundary clock c and is owed from clock c+1. An owed refresh waits for the running access to finish and takes the very next clock. No new grant starts while a refresh is owed. `cpu_gnt_o` and `ref_stb_o` are never high together.
- R8: `mode_i` is sampled only on the first clock of a period and governs from the following clock. A change made mid-period does not alter the rest of that period.
- R9: Under every policy, and across policy changes, each row is refreshed at least once within every period.
- R10: `cpu_req_i` is a level. An idle arbiter that sees it grants in the next clock, and `cpu_gnt_o` then stays high for exactly ACC_CYCLES consecutive clocks, one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Refresh policy: 0 burst, 1 interleaved, 2 or 3 spread |
| cpu_req_i | input | 1 | Processor access request level |
| cpu_gnt_o | output | 1 | High during each clock of a granted access |
| busy_o | output | 1 | Processor lock-out caused by refresh |
| ref_stb_o | output | 1 | Refresh cycle strobe |
| ref_row_o | output | $clog2(ROWS) | Row refreshed when the strobe is high |
| period_done_o | output | 1 | Pulse on the refresh of the last row |

## Verification
The bound checker watches every clock for these rules:
- lock-out only ever coincides with a refresh strobe;
- grant and strobe exclude each other;
- the row steps by one per strobe and holds otherwise, and returns to zero after the wrap pulse;
- the interleaved policy never locks out and always appends a refresh to an ended access;
- a grant lasts at least two clocks.

Other behaviour only the bench scenarios can show. These cover:
- the exact placement of the burst and of each spread slot within the period;
- an owed refresh deferred behind a running access and then taking priority over a pending request;
- a mid-period policy change having no effect until the next period;
- complete row coverage in every period across all three policies.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

   typedef enum logic [1:0] {
      POL_CENT  = 2'd0,
      POL_DIST  = 2'd1,
      POL_ASYNC = 2'd2
   } policy_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_REF  = 2'd2
   } phase_e;

   // codes 2 and 3 both select the spread policy
   function automatic policy_e decode_policy(input logic [1:0] code);
      case (code)
         2'd0:    return POL_CENT;
         2'd1:    return POL_DIST;
         default: return POL_ASYNC;
      endcase
   endfunction

endpackage

// File: rtl/rfs_timer.sv
module rfs_timer #(
   parameter int PERIOD_CLKS = 200,
   parameter int SLOT_CLKS   = 25
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic period_start_o,
   output logic slot_start_o
);
   localparam int PCW = (PERIOD_CLKS > 2) ? $clog2(PERIOD_CLKS) : 1;
   localparam int SCW = (SLOT_CLKS > 2) ? $clog2(SLOT_CLKS) : 1;

   logic [PCW-1:0] per_q;
   logic [SCW-1:0] slot_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         per_q <= '0;
      end else if (per_q == PCW'(PERIOD_CLKS - 1)) begin
         per_q <= '0;
      end else begin
         per_q <= per_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         slot_q <= '0;
      end else if (slot_q == SCW'(SLOT_CLKS - 1)) begin
         slot_q <= '0;
      end else begin
         slot_q <= slot_q + 1'b1;
      end
   end

   assign period_start_o = (per_q == '0);
   assign slot_start_o   = (slot_q == '0);

endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
   parameter int ROWS = 8,
   localparam int RW = $clog2(ROWS)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          inc_i,
   output logic [RW-1:0] row_o,
   output logic          wrap_o
);
   logic [RW-1:0] row_q, row_nxt;
   logic          at_last;

   assign at_last = (row_q == RW'(ROWS - 1));

   generate
      if ((1 << RW) == ROWS) begin : g_pow2
         assign row_nxt = row_q + 1'b1;
      end else begin : g_mod
         assign row_nxt = at_last ? '0 : row_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         row_q <= '0;
      end else if (inc_i) begin
         row_q <= row_nxt;
      end
   end

   assign row_o  = row_q;
   assign wrap_o = inc_i && at_last;

endmodule

// File: rtl/rfs_arbiter.sv
module rfs_arbiter
   import rfs_pkg::*;
#(
   parameter int ROWS       = 8,
   parameter int ACC_CYCLES = 3
) (
   input  logic    clk_i,
   input  logic    rst_ni,
   input  policy_e policy_i,
   input  logic    req_i,
   input  logic    load_i,
   input  logic    due_i,
   output logic    ref_o,
   output logic    gnt_o,
   output logic    busy_o
);
   localparam int PW = $clog2(ROWS + 2);
   localparam int CW = (ACC_CYCLES > 2) ? $clog2(ACC_CYCLES) : 1;

   phase_e         st_q, st_d;
   logic [CW-1:0]  cnt_q, cnt_d;
   logic           cpu_q, cpu_d;
   logic [PW-1:0]  pend_q, pend_d;
   logic           interleave, owed, acc_last;

   assign interleave = (policy_i == POL_DIST);
   assign owed       = (pend_q != '0);
   assign acc_last   = (cnt_q == CW'(ACC_CYCLES - 1));

   // owed refresh count: a period load overrides, a slot adds one
   always_comb begin
      pend_d = pend_q;
      if (st_q == ST_REF && owed) begin
         pend_d = pend_q - 1'b1;
      end
      if (load_i) begin
         pend_d = PW'(ROWS);
      end else if (due_i) begin
         pend_d = pend_d + 1'b1;
      end
   end

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      cpu_d = cpu_q;
      case (st_q)
         ST_IDLE: begin
            cnt_d = '0;
            if (interleave) begin
               st_d  = ST_ACC;
               cpu_d = req_i;
            end else if (owed) begin
               st_d  = ST_REF;
               cpu_d = 1'b0;
            end else if (req_i) begin
               st_d  = ST_ACC;
               cpu_d = 1'b1;
            end
         end
         ST_ACC: begin
            if (!acc_last) begin
               cnt_d = cnt_q + 1'b1;
            end else begin
               cnt_d = '0;
               cpu_d = 1'b0;
               if (interleave || owed) begin
                  st_d = ST_REF;
               end else begin
                  st_d = ST_IDLE;
               end
            end
         end
         ST_REF: begin
            cnt_d = '0;
            if (interleave) begin
               st_d  = ST_ACC;
               cpu_d = req_i;
            end else if (pend_q > PW'(1)) begin
               st_d = ST_REF;
            end else begin
               st_d = ST_IDLE;
            end
         end
         default: begin
            st_d  = ST_IDLE;
            cpu_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         cpu_q  <= 1'b0;
         pend_q <= '0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         cpu_q  <= cpu_d;
         pend_q <= pend_d;
      end
   end

   assign ref_o  = (st_q == ST_REF);
   assign gnt_o  = (st_q == ST_ACC) && cpu_q;
   assign busy_o = (st_q == ST_REF) && !interleave;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
   import rfs_pkg::*;
#(
   parameter int ROWS       = 8,
   parameter int CLK_KHZ    = 100,
   parameter int PERIOD_US  = 2000,
   parameter int ACC_CYCLES = 3,
   localparam int RW = $clog2(ROWS)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [1:0]    mode_i,
   input  logic          cpu_req_i,
   output logic          cpu_gnt_o,
   output logic          busy_o,
   output logic          ref_stb_o,
   output logic [RW-1:0] ref_row_o,
   output logic          period_done_o
);
   localparam int PERIOD_CLKS = (CLK_KHZ * PERIOD_US) / 1000;
   localparam int SLOT_CLKS   = PERIOD_CLKS / ROWS;

   // elaboration-time parameter checks
   generate
      if (ROWS < 2) begin : g_chk_rows
         $error("ROWS must be at least 2");
      end
      if (ACC_CYCLES < 2) begin : g_chk_acc
         $error("ACC_CYCLES must be at least 2");
      end
      if (PERIOD_CLKS % ROWS != 0) begin : g_chk_div
         $error("period in clocks must be a multiple of ROWS");
      end
      if (SLOT_CLKS <= ACC_CYCLES + 2) begin : g_chk_slot
         $error("slot spacing too short for one access plus one refresh");
      end
   endgenerate

   logic    per_start, slot_start;
   policy_e mode_act, mode_eff, mode_new;
   logic    load_burst, slot_due;
   logic    ref_w, row_wrap;

   rfs_timer #(
      .PERIOD_CLKS (PERIOD_CLKS),
      .SLOT_CLKS   (SLOT_CLKS)
   ) u_timer (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .period_start_o (per_start),
      .slot_start_o   (slot_start)
   );

   assign mode_new = decode_policy(mode_i);
   assign mode_eff = per_start ? mode_new : mode_act;

   // policy held for the whole period
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_act <= POL_CENT;
      end else if (per_start) begin
         mode_act <= mode_new;
      end
   end

   assign load_burst = per_start && (mode_new == POL_CENT);
   assign slot_due   = slot_start && (mode_eff == POL_ASYNC);

   rfs_arbiter #(
      .ROWS       (ROWS),
      .ACC_CYCLES (ACC_CYCLES)
   ) u_arb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .policy_i (mode_act),
      .req_i    (cpu_req_i),
      .load_i   (load_burst),
      .due_i    (slot_due),
      .ref_o    (ref_w),
      .gnt_o    (cpu_gnt_o),
      .busy_o   (busy_o)
   );

   rfs_row_ctr #(
      .ROWS (ROWS)
   ) u_rows (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (ref_w),
      .row_o  (ref_row_o),
      .wrap_o (row_wrap)
   );

   assign ref_stb_o     = ref_w;
   assign period_done_o = row_wrap;

endmodule

// File: rtl/rfs_sched_checker.sv
module rfs_sched_checker
   import rfs_pkg::*;
#(
   parameter int ROWS = 8,
   localparam int RW = $clog2(ROWS)
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          cpu_gnt_o,
   input logic          busy_o,
   input logic          ref_stb_o,
   input logic [RW-1:0] ref_row_o,
   input logic          period_done_o,
   input policy_e       mode_act
);

   a_r4_busy_needs_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> ref_stb_o);

   a_r7_grant_excludes_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_stb_o |-> !cpu_gnt_o);

   a_r2_row_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ref_stb_o && ref_row_o != RW'(ROWS - 1)) |=> (ref_row_o == $past(ref_row_o) + 1'b1));

   a_r2_row_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ref_stb_o |=> $stable(ref_row_o));

   a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      period_done_o |=> (ref_row_o == '0));

   a_r5_no_dead_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_act == POL_DIST) |-> !busy_o);

   a_r5_refresh_after_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(cpu_gnt_o) && $past(mode_act) == POL_DIST) |-> ref_stb_o);

   a_r10_grant_lasts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cpu_gnt_o) |=> cpu_gnt_o);

endmodule

bind dram_refresh_sched rfs_sched_checker #(
   .ROWS (ROWS)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .cpu_gnt_o     (cpu_gnt_o),
   .busy_o        (busy_o),
   .ref_stb_o     (ref_stb_o),
   .ref_row_o     (ref_row_o),
   .period_done_o (period_done_o),
   .mode_act      (mode_act)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
   localparam int ROWS = 8;
   localparam int ACC  = 3;
   localparam int PER  = 200;       // 100 kHz * 2000 us / 1000
   localparam int SLOT = PER / ROWS;
   localparam int RW   = $clog2(ROWS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic          req = 1'b0;
   logic          gnt, busy, stb, pd;
   logic [RW-1:0] row;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;
   bit cent_win = 0, async_win = 0, quiet_win = 0;

   always #5 clk = ~clk;

   dram_refresh_sched #(
      .ROWS(ROWS), .CLK_KHZ(100), .PERIOD_US(2000), .ACC_CYCLES(ACC)
   ) u0 (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cpu_req_i(req),
      .cpu_gnt_o(gnt), .busy_o(busy), .ref_stb_o(stb),
      .ref_row_o(row), .period_done_o(pd)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s cycle %0d: got %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   // per-cycle scoreboard built from the requirements
   int  cm = 0;            // policy in force: 0 burst, 1 interleaved, 2 spread
   int  exp_row = 0;
   int  tdue = 0, sdone = 0, ocur = 0, oprev = 0;
   int  gnt_run = 0, last_stb = 0, dist_cnt = 0;
   bit  gnt_prev = 0;
   logic [ROWS-1:0] mask = '0;

   always @(negedge clk) begin
      int off, newpol, eff;
      string tg;
      if (rst_n && !done) begin
         off = cyc % PER;
         tg = (cm == 0) ? "R4" : (cm == 1) ? "R5" : "R6";
         if (stb) chk(int'(row) == exp_row, "R2 row", int'(row), exp_row);
         chk(pd == (stb && exp_row == ROWS - 1), "R3 wrap pulse", int'(pd), int'(stb && exp_row == ROWS - 1));
         chk(busy == (stb && cm != 1), {tg, " busy"}, int'(busy), int'(stb && cm != 1));
         chk(!(stb && gnt), "R7 exclusive", int'(stb && gnt), 0);
         if (cent_win) chk(stb == (off >= 2 && off < 2 + ROWS), "R4 burst place", int'(stb), int'(off >= 2 && off < 2 + ROWS));
         if (async_win) chk(stb == ((off % SLOT) == 2), "R6 slot place", int'(stb), int'((off % SLOT) == 2));
         if (quiet_win) chk(!stb, "R8 late mode change", int'(stb), 0);
         oprev = ocur;
         ocur  = tdue - sdone;
         if (cm != 1) begin
            if (gnt && !gnt_prev) chk(oprev == 0, "R7 grant while owed", oprev, 0);
            if (!gnt && gnt_prev && oprev > 0) chk(stb, "R7 refresh after access", int'(stb), 1);
         end
         if (cm == 1 && !gnt && gnt_prev) chk(stb, "R5 appended refresh", int'(stb), 1);
         if (cm == 1 && stb) begin
            dist_cnt++;
            if (dist_cnt >= 2) chk(cyc - last_stb == ACC + 1, "R5 spacing", cyc - last_stb, ACC + 1);
         end
         if (cm != 1) dist_cnt = 0;
         if (gnt) gnt_run++;
         else begin
            if (gnt_prev) chk(gnt_run == ACC, "R10 grant length", gnt_run, ACC);
            gnt_run = 0;
         end
         // bookkeeping
         if (stb && cm != 1) sdone++;
         newpol = (mode == 2'd0) ? 0 : (mode == 2'd1) ? 1 : 2;
         eff = (off == 0) ? newpol : cm;
         if (off == 0 && newpol == 0) tdue = sdone + ROWS;
         else if ((off % SLOT) == 0 && eff == 2) tdue++;
         if (stb) begin
            mask[row] = 1'b1;
            exp_row = (exp_row + 1) % ROWS;
            last_stb = cyc;
         end
         if (off == PER - 1) begin
            chk(&mask, "R9 period coverage", int'(mask), (1 << ROWS) - 1);
            mask = '0;
         end
         if (off == 0) cm = newpol;
         gnt_prev = gnt;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!stb && !busy && !gnt && !pd && row == '0, "R1 reset state",
          int'({stb, busy, gnt, pd}), 0);
      chk(row == '0, "R1 reset row", int'(row), 0);
      cent_win = 1;
      @(posedge clk);
      #2 rst_n = 1'b1;
      // period 0: burst, one single access
      wait_cyc(50); req = 1'b1;
      wait_cyc(51);
      chk(gnt == 1'b1, "R10 grant next clock", int'(gnt), 1);
      req = 1'b0;
      // period 1 burst; continuous traffic into period 2
      wait_cyc(390); cent_win = 0;
      wait_cyc(395); req = 1'b1;
      // period 2 burst deferred behind access; mid-period switch to spread
      wait_cyc(500); mode = 2'd2;
      wait_cyc(505); quiet_win = 1;
      wait_cyc(590); quiet_win = 0;
      // period 3 spread under full traffic
      wait_cyc(790); req = 1'b0;
      // periods 4 and 5 spread, idle; code 3 also selects spread
      wait_cyc(800); async_win = 1;
      wait_cyc(900); mode = 2'd3;
      wait_cyc(1100); mode = 2'd1;
      wait_cyc(1150); async_win = 0;
      // periods 6 and 7 interleaved, idle then busy
      wait_cyc(1400); req = 1'b1;
      wait_cyc(1500); mode = 2'd0;
      wait_cyc(1590); req = 1'b0;
      // period 8 burst after interleaved, period 9 clean burst
      wait_cyc(1790); cent_win = 1;
      wait_cyc(2000);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule